// File: doc/BRIEF.md
# Double-Precision Reciprocal Square-Root Seed Unit

This unit produces a coarse estimate of 1/sqrt(x) for an IEEE-754 binary64 operand. Software or a later iteration stage refines the estimate. The operand arrives over a 32-bit path, one half per cycle: the low word in the launch cycle and the high word in the cycle after. The result leaves the same way, low word first. Launches may occur in every cycle. The high word of one operation therefore shares a cycle with the low word of the next, so the unit has two 32-bit operand inputs.

Each operand is first sorted into a class. Operands outside the normal positive range each have a fixed result and a fixed set of status flags. A normal positive operand gets a halved and negated exponent. Its mantissa seed comes from a table indexed by the exponent parity and the top seven fraction bits, and every result bit below the seed is zero. The flags accompany the high result word.

Top module: `rsq_core`

## Requirements
- R1: A signalling NaN operand (exponent all ones, fraction nonzero, fraction bit 51 clear) gives result 0x7FFF_FFFF_FFFF_FFFF and flags = 6'b000011. The flags vector encodes invalid in bit 0, NaN input in bit 1, divide-by-zero in bit 2, inexact in bit 3, denormal input in bit 4 and infinity output in bit 5.
- R2: A quiet NaN operand (exponent all ones, fraction bit 51 set) gives result 0x7FFF_FFFF_FFFF_FFFF and flags = 6'b000010 (NaN input only).
- R3: A negative operand that is neither zero, denormal nor NaN gives result 0x7FFF_FFFF_FFFF_FFFF and flags = 6'b000001 (invalid only). This includes negative infinity.
- R4: A denormal operand of either sign gives infinity carrying the operand's sign and flags = 6'b011100 (divide-by-zero, inexact, denormal input).
- R5: A zero operand of either sign gives infinity carrying the operand's sign and flags = 6'b100100 (divide-by-zero, infinity output).
- R6: Positive infinity gives +0 with flags = 0.
- R7: A normal positive operand with biased exponent e gives a positive result whose biased exponent is (3068 - e) >> 1 and whose flags are 0. Its low result word is zero, and only the top 10 fraction bits (result bits 51..42) may be nonzero.
- R8: For a normal positive operand, the result lies within a relative error of 2^-8 of the real value 1/sqrt(x).
- R9: Suppose start and op_lo are sampled at clock edge k and op_hi at edge k+1. Then lo_vld and res_lo appear after edge k+1, and hi_vld, res_hi and flags appear after edge k+2. Both valids are otherwise low.
- R10: Operations launched on consecutive cycles each complete, with no lost or merged result.
- R11: While reset is asserted and after it is released, lo_vld and hi_vld are low. flags is zero whenever hi_vld is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches an operation; op_lo holds its low word |
| op_lo | input | 32 | Low operand word of the operation launched this cycle |
| op_hi | input | 32 | High operand word of the operation launched last cycle |
| lo_vld | output | 1 | res_lo holds a result low word |
| res_lo | output | 32 | Result low word |
| hi_vld | output | 1 | res_hi and flags hold a result high word and its status |
| res_hi | output | 32 | Result high word |
| flags | output | 6 | Status: invalid, NaN input, divide-by-zero, inexact, denormal input, infinity output (bits 0..5) |

## Verification
Two things collide in the same cycle during back-to-back launches. On the input side, the high-word read of one operation coincides with the low-word read of the next. On the output side, one operation's low-word write coincides with the previous operation's high-word write. The bench provokes both with long unbroken runs of launches that mix special classes and random normals, broken by occasional idle cycles. A behavioural model keyed by cycle number predicts each half of each result and each flag set. It judges every cycle, so a stale, swapped or merged half shows up at the cycle where it appears.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int unsigned EXP_W  = 11;
  localparam int unsigned FRAC_W = 52;
  localparam int unsigned BIAS   = 1023;
  localparam int unsigned FLAG_W = 6;

  localparam int unsigned FL_INV  = 0;
  localparam int unsigned FL_NANI = 1;
  localparam int unsigned FL_DZ   = 2;
  localparam int unsigned FL_INEX = 3;
  localparam int unsigned FL_DENI = 4;
  localparam int unsigned FL_INFO = 5;

  localparam logic [63:0] CANON_NAN = 64'h7FFF_FFFF_FFFF_FFFF;

  typedef enum logic [2:0] {
    CL_SNAN, CL_QNAN, CL_NEG, CL_DEN, CL_ZERO, CL_PINF, CL_NORM
  } op_class_e;

  // (3*BIAS - 1 - e) >> 1 : halved, negated exponent with parity folded in
  function automatic logic [EXP_W-1:0] halve_exp(input logic [EXP_W-1:0] e);
    logic [EXP_W:0] t;
    t = (EXP_W+1)'(3*BIAS - 1) - {1'b0, e};
    return t[EXP_W:1];
  endfunction

  function automatic logic [31:0] isqrt64(input logic [63:0] v);
    logic [63:0] acc;
    logic [63:0] trial;
    acc = '0;
    for (int b = 31; b >= 0; b--) begin
      trial = acc | (64'd1 << b);
      if (trial * trial <= v) acc = trial;
    end
    return acc[31:0];
  endfunction

  // Seed fraction for one table slot, taken at the midpoint of its interval.
  // par=0: value 2/sqrt(m); par=1: value sqrt(2/m); both lie in [1,2).
  function automatic logic [31:0] seed_frac(input int unsigned par, input int unsigned idx,
                                            input int unsigned iw, input int unsigned sw);
    logic [63:0] den;
    logic [63:0] num;
    logic [63:0] q;
    logic [63:0] r;
    den = 64'((64'd1 << (iw + 1)) + 64'(2 * idx + 1));
    num = (par != 0 ? 64'd2 : 64'd4) << (iw + 1 + 2 * sw + 2);
    q   = 64'(isqrt64(num / den));
    r   = (q + 64'd1) >> 1;
    return 32'(r - (64'd1 << sw));
  endfunction
endpackage

// File: rtl/rsq_classify.sv
module rsq_classify
  import rsq_pkg::*;
(
  input  logic [63:0] opnd,
  output op_class_e   cls
);
  logic                  sgn;
  logic [EXP_W-1:0]      ex;
  logic [FRAC_W-1:0]     fr;

  assign sgn = opnd[63];
  assign ex  = opnd[62:FRAC_W];
  assign fr  = opnd[FRAC_W-1:0];

  always_comb begin
    if (ex == '1) begin
      if (fr != '0) cls = fr[FRAC_W-1] ? CL_QNAN : CL_SNAN;
      else          cls = sgn ? CL_NEG : CL_PINF;
    end else if (ex == '0) begin
      cls = (fr == '0) ? CL_ZERO : CL_DEN;
    end else begin
      cls = sgn ? CL_NEG : CL_NORM;
    end
  end
endmodule

// File: rtl/rsq_seed_rom.sv
module rsq_seed_rom
  import rsq_pkg::*;
#(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned SEED_W = 10
) (
  input  logic [IDX_W:0]    idx,
  output logic [SEED_W-1:0] seed
);
  localparam int unsigned DEPTH = 1 << (IDX_W + 1);
  localparam int unsigned HALF  = 1 << IDX_W;

  logic [SEED_W-1:0] tbl [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    localparam logic [31:0] VAL = seed_frac(j / HALF, j % HALF, IDX_W, SEED_W);
    assign tbl[j] = VAL[SEED_W-1:0];
  end

  assign seed = tbl[idx];
endmodule

// File: rtl/rsq_exp_path.sv
module rsq_exp_path
  import rsq_pkg::*;
(
  input  logic [EXP_W-1:0] ex_in,
  output logic [EXP_W-1:0] ex_out,
  output logic             odd_pow
);
  // unbiased exponent is odd exactly when the biased one is even
  assign odd_pow = ~ex_in[0];
  assign ex_out  = halve_exp(ex_in);
endmodule

// File: rtl/rsq_core.sv
module rsq_core
  import rsq_pkg::*;
#(
  parameter int unsigned HW     = 32,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned SEED_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HW-1:0]     op_lo,
  input  logic [HW-1:0]     op_hi,
  output logic              lo_vld,
  output logic [HW-1:0]     res_lo,
  output logic              hi_vld,
  output logic [HW-1:0]     res_hi,
  output logic [FLAG_W-1:0] flags
);
  localparam int unsigned DW     = 2 * HW;
  localparam int unsigned PAD_W  = FRAC_W - SEED_W;

  // stage 1: low word captured at the end of the launch cycle
  logic          vld1;
  logic [HW-1:0] lo1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld1 <= 1'b0;
      lo1  <= '0;
    end else begin
      vld1 <= start;
      if (start) lo1 <= op_lo;
    end
  end

  // second cycle: the whole operand is available
  logic [DW-1:0]     opnd;
  op_class_e         cls;
  logic [EXP_W-1:0]  ex_half;
  logic              odd_pow;
  logic [SEED_W-1:0] seed;
  logic              norm_path;
  logic [DW-1:0]     res_w;
  logic [FLAG_W-1:0] fl_w;

  assign opnd = {op_hi, lo1};

  rsq_classify u_cls (
    .opnd (opnd),
    .cls  (cls)
  );

  rsq_exp_path u_exp (
    .ex_in   (opnd[62:FRAC_W]),
    .ex_out  (ex_half),
    .odd_pow (odd_pow)
  );

  rsq_seed_rom #(
    .IDX_W  (IDX_W),
    .SEED_W (SEED_W)
  ) u_rom (
    .idx  ({odd_pow, opnd[FRAC_W-1 -: IDX_W]}),
    .seed (seed)
  );

  assign norm_path = (cls == CL_NORM);

  always_comb begin
    res_w = '0;
    fl_w  = '0;
    unique case (cls)
      CL_SNAN: begin
        res_w = CANON_NAN;
        fl_w[FL_INV]  = 1'b1;
        fl_w[FL_NANI] = 1'b1;
      end
      CL_QNAN: begin
        res_w = CANON_NAN;
        fl_w[FL_NANI] = 1'b1;
      end
      CL_NEG: begin
        res_w = CANON_NAN;
        fl_w[FL_INV] = 1'b1;
      end
      CL_DEN: begin
        res_w = {opnd[63], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        fl_w[FL_DZ]   = 1'b1;
        fl_w[FL_INEX] = 1'b1;
        fl_w[FL_DENI] = 1'b1;
      end
      CL_ZERO: begin
        res_w = {opnd[63], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        fl_w[FL_DZ]   = 1'b1;
        fl_w[FL_INFO] = 1'b1;
      end
      CL_PINF: begin
        res_w = '0;
      end
      default: begin
        res_w = {1'b0, ex_half, seed, {PAD_W{1'b0}}};
      end
    endcase
  end

  // stage 2: low result word written, high word and flags held
  logic              vld2;
  logic [HW-1:0]     rlo2;
  logic [HW-1:0]     rhi2;
  logic [FLAG_W-1:0] fl2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld2 <= 1'b0;
      rlo2 <= '0;
      rhi2 <= '0;
      fl2  <= '0;
    end else begin
      vld2 <= vld1;
      if (vld1) begin
        rlo2 <= res_w[HW-1:0];
        rhi2 <= res_w[DW-1:HW];
      end
      fl2 <= vld1 ? fl_w : '0;
    end
  end

  // stage 3: high result word and flags written
  logic              vld3;
  logic [HW-1:0]     rhi3;
  logic [FLAG_W-1:0] fl3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld3 <= 1'b0;
      rhi3 <= '0;
      fl3  <= '0;
    end else begin
      vld3 <= vld2;
      if (vld2) rhi3 <= rhi2;
      fl3 <= vld2 ? fl2 : '0;
    end
  end

  assign lo_vld = vld2;
  assign res_lo = rlo2;
  assign hi_vld = vld3;
  assign res_hi = rhi3;
  assign flags  = fl3;
endmodule

// File: rtl/rsq_chk.sv
module rsq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        lo_vld,
  input logic        hi_vld,
  input logic [31:0] res_hi,
  input logic [5:0]  flags,
  input logic        norm_path
);
  // R9
  launch_to_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ##1 lo_vld);

  // R9
  lo_to_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_vld |=> hi_vld);

  // R1
  invalid_gives_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_vld && flags[0]) |-> (res_hi == 32'h7FFF_FFFF));

  // R2
  nan_in_gives_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_vld && flags[1]) |-> (res_hi == 32'h7FFF_FFFF && !flags[2]));

  // R4
  denorm_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_vld && flags[4]) |-> (flags[2] && flags[3] && !flags[5] && res_hi[30:0] == 31'h7FF0_0000));

  // R5
  zero_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_vld && flags[5]) |-> (flags[2] && !flags[3] && res_hi[30:0] == 31'h7FF0_0000));

  // R7
  quiet_result_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_vld && flags == 6'd0) |-> !res_hi[31]);

  // R11
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_vld |-> (flags == 6'd0));

  // R7
  norm_seed_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    norm_path |=> ##1 (hi_vld && flags == 6'd0 && res_hi[9:0] == 10'd0));
endmodule

bind rsq_core rsq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .lo_vld    (lo_vld),
  .hi_vld    (hi_vld),
  .res_hi    (res_hi),
  .flags     (flags),
  .norm_path (norm_path && vld1)
);

// File: tb/rsq_core_tb.sv
`timescale 1ns/1ps
module rsq_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] op_lo = '0;
  logic [31:0] op_hi = '0;
  logic        lo_vld;
  logic [31:0] res_lo;
  logic        hi_vld;
  logic [31:0] res_hi;
  logic [5:0]  flags;

  always #2 clk = ~clk;

  rsq_core u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op_lo  (op_lo),
    .op_hi  (op_hi),
    .lo_vld (lo_vld),
    .res_lo (res_lo),
    .hi_vld (hi_vld),
    .res_hi (res_hi),
    .flags  (flags)
  );

  int  cyc = 0;
  int  nchk = 0;
  int  nerr = 0;
  bit  done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] elo  [int];
  logic [31:0] ehi  [int];
  logic [5:0]  efl  [int];
  string       ltag [int];
  string       htag [int];
  bit          enrm [int];
  bit          eovl [int];
  logic [63:0] eop  [int];

  logic [63:0] ops [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", req, what, cyc, act, exp);
    end
  endtask

  function automatic void model(input logic [63:0] x, output logic [63:0] r,
                                output logic [5:0] fl, output string tag, output bit nrm);
    int          e;
    logic [51:0] f;
    bit          s;
    e = int'(x[62:52]);
    f = x[51:0];
    s = x[63];
    r = 64'd0; fl = 6'd0; nrm = 1'b0; tag = "R7";
    if (e == 2047 && f != 0) begin
      r = 64'h7FFF_FFFF_FFFF_FFFF;
      if (f[51]) begin fl = 6'b000010; tag = "R2"; end
      else       begin fl = 6'b000011; tag = "R1"; end
    end else if (e == 0 && f == 0) begin
      r = {s, 11'h7FF, 52'd0}; fl = 6'b100100; tag = "R5";
    end else if (e == 0) begin
      r = {s, 11'h7FF, 52'd0}; fl = 6'b011100; tag = "R4";
    end else if (s) begin
      r = 64'h7FFF_FFFF_FFFF_FFFF; fl = 6'b000001; tag = "R3";
    end else if (e == 2047) begin
      r = 64'd0; tag = "R6";
    end else begin
      nrm = 1'b1;
    end
  endfunction

  task automatic check_now();
    string pt;
    pt = (eovl.exists(cyc) && eovl[cyc]) ? "R10" : "R9";
    if (elo.exists(cyc)) begin
      chk(lo_vld == 1'b1, pt, "low valid", 64'(lo_vld), 64'd1);
      chk(res_lo == elo[cyc], ltag[cyc], "low word", 64'(res_lo), 64'(elo[cyc]));
    end else begin
      chk(lo_vld == 1'b0, "R9", "low idle", 64'(lo_vld), 64'd0);
    end
    if (ehi.exists(cyc)) begin
      chk(hi_vld == 1'b1, "R9", "high valid", 64'(hi_vld), 64'd1);
      if (enrm[cyc]) begin
        int  e;
        int  want_e;
        real refv;
        real got;
        real err;
        e      = int'(eop[cyc][62:52]);
        want_e = (3068 - e) / 2;
        chk(int'(res_hi[30:20]) == want_e, "R7", "exponent", 64'(res_hi[30:20]), 64'(want_e));
        chk(!res_hi[31] && res_hi[9:0] == 10'd0 && flags == 6'd0, "R7", "sign/tail/flags",
            {res_hi, 26'd0, flags}, {res_hi & 32'h7FFF_FC00, 32'd0});
        refv = 1.0 / $sqrt($bitstoreal(eop[cyc]));
        got  = $bitstoreal({res_hi, 32'd0});
        err  = got / refv - 1.0;
        if (err < 0.0) err = -err;
        chk(err < 0.00390625, "R8", "relative error", $realtobits(got), $realtobits(refv));
      end else begin
        chk(res_hi == ehi[cyc], htag[cyc], "high word", 64'(res_hi), 64'(ehi[cyc]));
        chk(flags == efl[cyc], htag[cyc], "flags", 64'(flags), 64'(efl[cyc]));
      end
    end else begin
      chk(hi_vld == 1'b0 && flags == 6'd0, "R11", "high idle", {hi_vld, flags}, 64'd0);
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [63:0] pend;
    bit          have_pend;
    int          i;
    int          k;

    // special operands
    ops.push_back(64'h7FF0_0000_0000_0001);  // +SNaN
    ops.push_back(64'hFFF4_0000_0000_0000);  // -SNaN
    ops.push_back(64'h7FF8_0000_0000_0000);  // +QNaN
    ops.push_back(64'hFFF8_0000_1234_0000);  // -QNaN
    ops.push_back(64'hBFF0_0000_0000_0000);  // -1.0
    ops.push_back(64'hFFF0_0000_0000_0000);  // -inf
    ops.push_back(64'hC123_4567_89AB_CDEF);  // negative normal
    ops.push_back(64'h0000_0000_0000_0001);  // +denormal
    ops.push_back(64'h800F_FFFF_FFFF_FFFF);  // -denormal
    ops.push_back(64'h0000_0000_0000_0000);  // +0
    ops.push_back(64'h8000_0000_0000_0000);  // -0
    ops.push_back(64'h7FF0_0000_0000_0000);  // +inf
    // normal boundary operands
    ops.push_back(64'h4010_0000_0000_0000);  // 4.0
    ops.push_back(64'h3FF0_0000_0000_0000);  // 1.0
    ops.push_back(64'h4000_0000_0000_0000);  // 2.0
    ops.push_back(64'h3FFF_FFFF_FFFF_FFFF);  // just below 2.0
    ops.push_back(64'h0010_0000_0000_0000);  // smallest normal
    ops.push_back(64'h7FEF_FFFF_FFFF_FFFF);  // largest normal
    for (int n = 0; n < 60; n++) begin
      logic [10:0] e;
      e = 11'(1 + ($urandom % 2046));
      ops.push_back({1'b0, e, 20'($urandom), 32'($urandom)});
      if (n % 10 == 5) ops.push_back(64'h0000_0000_0000_0000);
      if (n % 10 == 7) ops.push_back(64'hFFF0_0000_0000_0001);
    end

    // reset phase
    repeat (3) begin
      @(negedge clk);
      chk(lo_vld == 1'b0 && hi_vld == 1'b0 && flags == 6'd0, "R11", "in reset",
          {lo_vld, hi_vld, flags}, 64'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(lo_vld == 1'b0 && hi_vld == 1'b0 && flags == 6'd0, "R11", "after reset",
        {lo_vld, hi_vld, flags}, 64'd0);

    have_pend = 1'b0;
    pend = '0;
    i = 0;
    k = 0;
    while (i < ops.size() || have_pend || k < 4 || elo.exists(cyc) || ehi.exists(cyc)
           || ehi.exists(cyc + 1) || ehi.exists(cyc + 2)) begin
      bit go;
      @(negedge clk);
      check_now();
      go = (i < ops.size()) && (k % 11 != 10);
      if (have_pend) begin
        logic [63:0] r;
        logic [5:0]  fl;
        string       tg;
        bit          nr;
        model(pend, r, fl, tg, nr);
        elo[cyc + 1]  = r[31:0];
        ltag[cyc + 1] = tg;
        eovl[cyc + 1] = go;
        ehi[cyc + 2]  = r[63:32];
        efl[cyc + 2]  = fl;
        htag[cyc + 2] = tg;
        enrm[cyc + 2] = nr;
        eop[cyc + 2]  = pend;
        op_hi = pend[63:32];
      end else begin
        op_hi = $urandom;
      end
      start = go;
      if (go) begin
        op_lo = ops[i][31:0];
        pend  = ops[i];
        i++;
      end else begin
        op_lo = $urandom;
      end
      have_pend = go;
      k++;
      if (k > 5000) break;
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule